// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register set on a simple 32-bit bus. The bus carries an address, a write strobe, write data and read data. Read data comes back one cycle after the address is presented. Each pin has a stored output value and a direction bit, which together drive the pad output and the pad output enable. The pad input is passed through a two-flop synchroniser. Software reads the synchronised level, and the same level feeds the interrupt detectors.

Every pin can raise an interrupt on a low level, a high level, a rising edge or a falling edge. The choice is made by a two-bit field in one of two sensitivity words. A separate per-pin "any edge" bit overrides that field and flags both transitions. Detected events are latched in a status word that software clears by writing ones. The status is masked by an enable word, and the result drives two request lines: one collects pins 0 to 15 and the other collects pins 16 to 31.

Register offsets (byte addresses): 0x00 output value, 0x04 direction, 0x08 synchronised pad level (read-only), 0x0C sensitivity for pins 0–15, 0x10 sensitivity for pins 16–31, 0x14 interrupt enable, 0x18 interrupt status, 0x1C any-edge select.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output value, direction, both sensitivity words, enable and any-edge registers read as zero, `pad_out` and `pad_oe` are zero, and both request lines are low.
- R2: `pad_out` equals the output value register and `pad_oe` equals the direction register, where a direction bit of 1 drives the pin. A read of offset 0x00 returns the stored output value, whatever level is on the pad.
- R3: A read of offset 0x08 returns the pad input after two synchronising flops. A write to 0x08 changes nothing.
- R4: `bus_rdata` holds the register selected by `bus_addr` one clock earlier. An unmapped offset reads as zero.
- R5: The sensitivity field of pin p sits at bits [2*(p mod 16)+1 : 2*(p mod 16)]. That field is in the word at 0x0C for p < 16 and in the word at 0x10 for p >= 16.
- R6: Field value 00 selects low level and 01 selects high level. A level-sensitive pin sets its status bit on every cycle its synchronised level is asserted, so a clear only sticks once the level has gone away.
- R7: Field value 10 sets status on a 0-to-1 change of the synchronised level. Field value 11 sets status on a 1-to-0 change. The opposite transition does not set status.
- R8: When a pin's bit at offset 0x1C is 1, both transitions set status and the pin's sensitivity field is ignored. In particular, a steady level sets nothing.
- R9: Writing 1 to a bit at offset 0x18 clears that status bit. Writing 0 leaves it unchanged.
- R10: If a detected event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq_lo` is the OR of status AND enable over pins 0–15, and `irq_hi` is the same over pins 16–31. An enable bit of 1 lets the pin through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq_lo | output | 1 | Request line for pins 0–15 |
| irq_hi | output | 1 | Request line for pins 16–31 |

## Verification
Several properties are checked on every cycle by the assertions:
- every detected event is present in the status on the next cycle, including when a clearing write lands on the same cycle;
- a status bit that is cleared and has no event reads zero afterwards;
- a request line can be high only while some enable bit in its half is set;
- the output enables move only after a write to the direction offset;
- an unmapped read returns zero.

Other behaviours can only be shown by the bench's scenarios. These are the mapping from each two-bit code to the condition it detects, the placement of each field inside the two sensitivity words, the override by the any-edge bit, and the re-setting of a level-sensitive status bit after it is cleared. Each scenario is built from a chosen pad history and its result is compared with the expected status.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFS_OUT   = 8'h00;
  localparam logic [7:0] OFS_DIR   = 8'h04;
  localparam logic [7:0] OFS_PAD   = 8'h08;
  localparam logic [7:0] OFS_SNSLO = 8'h0C;
  localparam logic [7:0] OFS_SNSHI = 8'h10;
  localparam logic [7:0] OFS_EN    = 8'h14;
  localparam logic [7:0] OFS_FLAG  = 8'h18;
  localparam logic [7:0] OFS_ANY   = 8'h1C;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_HIGH = 2'b01,
    SNS_RISE = 2'b10,
    SNS_FALL = 2'b11
  } sns_e;

  // One pin's trigger decision from its configuration and two samples.
  function automatic logic pin_trigger(logic [1:0] code, logic any_edge,
                                       logic cur, logic prev);
    if (any_edge) return cur ^ prev;
    case (sns_e'(code))
      SNS_LOW:  return ~cur;
      SNS_HIGH: return cur;
      SNS_RISE: return cur & ~prev;
      default:  return ~cur & prev;
    endcase
  endfunction

  // Next status: clear bits first, then OR in the new events (set wins).
  function automatic logic [31:0] flag_next(logic [31:0] cur, logic [31:0] clr,
                                            logic [31:0] evt);
    return (cur & ~clr) | evt;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   lvl,
  input  logic [2*NPINS-1:0] sns_all,
  input  logic [NPINS-1:0]   any_edge,
  output logic [NPINS-1:0]   evt
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign evt[p] = pin_trigger(sns_all[2*p +: 2], any_edge[p], lvl[p], prev_q[p]);
  end

  // R8
  any_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & any_edge) & ~(lvl ^ prev_q)) == '0);
endmodule

// File: rtl/gpio_status.sv
module gpio_status
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_evt,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_bits,
  input  logic [NPINS-1:0] enable,
  output logic [NPINS-1:0] flag_q,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] clr_eff;
  logic [NPINS-1:0] pending;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_next(flag_q, clr_eff, set_evt);
  end

  assign pending = flag_q & enable;
  assign irq_lo  = |pending[HALF-1:0];
  assign irq_hi  = |pending[NPINS-1:HALF];

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(set_evt)) == $past(set_evt)));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flag_q & $past(clr_bits & ~set_evt)) == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R11
  irq_lo_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (|enable[HALF-1:0]));

  // R11
  irq_hi_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> (|enable[NPINS-1:HALF]));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  logic [7:0]       ofs;
  logic [NPINS-1:0] out_q, dir_q, snslo_q, snshi_q, en_q, any_q;
  logic [NPINS-1:0] lvl_sync, evt, flag_q;
  logic             wr_flag, mapped;
  logic [NPINS-1:0] rd_mux;

  assign ofs = 8'(bus_addr);

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      snslo_q <= '0;
      snshi_q <= '0;
      en_q    <= '0;
      any_q   <= '0;
    end else if (bus_we) begin
      case (ofs)
        OFS_OUT:   out_q   <= bus_wdata;
        OFS_DIR:   dir_q   <= bus_wdata;
        OFS_SNSLO: snslo_q <= bus_wdata;
        OFS_SNSHI: snshi_q <= bus_wdata;
        OFS_EN:    en_q    <= bus_wdata;
        OFS_ANY:   any_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign wr_flag = bus_we && (ofs == OFS_FLAG);

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
  );

  gpio_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync),
    .sns_all({snshi_q, snslo_q}), .any_edge(any_q), .evt(evt)
  );

  gpio_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .set_evt(evt), .clr_we(wr_flag),
    .clr_bits(bus_wdata), .enable(en_q), .flag_q(flag_q),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // Read path
  always_comb begin
    mapped = 1'b1;
    case (ofs)
      OFS_OUT:   rd_mux = out_q;
      OFS_DIR:   rd_mux = dir_q;
      OFS_PAD:   rd_mux = lvl_sync;
      OFS_SNSLO: rd_mux = snslo_q;
      OFS_SNSHI: rd_mux = snshi_q;
      OFS_EN:    rd_mux = en_q;
      OFS_FLAG:  rd_mux = flag_q;
      OFS_ANY:   rd_mux = any_q;
      default: begin
        rd_mux = '0;
        mapped = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  // R2
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && ofs == OFS_DIR) |=> $stable(pad_oe));

  // R4
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/100ps
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata, rdata, pad_in, pad_out, pad_oe;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  typedef struct packed {
    logic [4:0] pin;
    logic [1:0] sns;
    logic       any;
    logic       from_lv;
    logic       to_lv;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  2'b00, 1'b0, 1'b1, 1'b0},
    '{5'd5,  2'b01, 1'b0, 1'b0, 1'b1},
    '{5'd17, 2'b10, 1'b0, 1'b0, 1'b1},
    '{5'd20, 2'b11, 1'b0, 1'b1, 1'b0},
    '{5'd31, 2'b10, 1'b0, 1'b1, 1'b0},
    '{5'd9,  2'b11, 1'b0, 1'b0, 1'b1},
    '{5'd16, 2'b00, 1'b1, 1'b1, 1'b0},
    '{5'd22, 2'b10, 1'b1, 1'b1, 1'b0},
    '{5'd12, 2'b01, 1'b1, 1'b1, 1'b1},
    '{5'd26, 2'b01, 1'b0, 1'b1, 1'b1},
    '{5'd0,  2'b00, 1'b0, 1'b1, 1'b1}
  };

  // Expected status after: settle at from_lv, clear, move to to_lv.
  function automatic logic want_flag(vec_t v);
    if (v.any) return v.from_lv != v.to_lv;
    case (v.sns)
      2'b00:   return !v.from_lv || !v.to_lv;
      2'b01:   return v.from_lv || v.to_lv;
      2'b10:   return !v.from_lv && v.to_lv;
      default: return v.from_lv && !v.to_lv;
    endcase
  endfunction

  function automatic string req_of(vec_t v);
    if (v.any) return "R8";
    return (v.sns[1]) ? "R7" : "R6";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pad_in = '1;
    idle(4);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    foreach (VECS[i]) begin end
    rd(8'h00, r); check("R1 out", r, 0);
    rd(8'h04, r); check("R1 dir", r, 0);
    rd(8'h0C, r); check("R1 snslo", r, 0);
    rd(8'h10, r); check("R1 snshi", r, 0);
    rd(8'h14, r); check("R1 en", r, 0);
    rd(8'h1C, r); check("R1 any", r, 0);

    // R2 output path and readback
    wr(8'h00, 32'h1234_5678);
    wr(8'h04, 32'hFFFF_0000);
    check("R2 pad_out", pad_out, 32'h1234_5678);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    pad_in = 32'h0F0F_A5A5;
    idle(4);
    rd(8'h00, r); check("R2 out readback", r, 32'h1234_5678);

    // R3 pad level, write ignored
    rd(8'h08, r); check("R3 pad level", r, 32'h0F0F_A5A5);
    wr(8'h08, 32'h0);
    rd(8'h08, r); check("R3 pad write ignored", r, 32'h0F0F_A5A5);

    // R4 unmapped read and latency
    rd(8'h24, r); check("R4 unmapped", r, 32'h0);
    @(negedge clk); addr = 8'h04;
    @(negedge clk); addr = 8'h00;
    check("R4 latency", rdata, 32'hFFFF_0000);
    @(negedge clk);
    check("R4 latency next", rdata, 32'h1234_5678);
    pad_in = '1;

    // Vector table: sensitivity, field placement, any-edge override
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic f;
      v = VECS[i];
      f = want_flag(v);
      pad_in = '1;
      wr(8'h0C, 0); wr(8'h10, 0); wr(8'h1C, 0); wr(8'h14, 0);
      idle(4);
      wr(8'h18, 32'hFFFF_FFFF);
      pad_in[v.pin] = v.from_lv;
      idle(4);
      if (v.pin < 16) wr(8'h0C, 32'(v.sns) << (2 * v.pin));
      else            wr(8'h10, 32'(v.sns) << (2 * (v.pin - 16)));
      wr(8'h1C, 32'(v.any) << v.pin);
      wr(8'h14, 32'h1 << v.pin);
      idle(4);
      wr(8'h18, 32'hFFFF_FFFF);
      idle(2);
      pad_in[v.pin] = v.to_lv;
      idle(6);
      rd(8'h18, r);
      check($sformatf("R5 %s vec %0d status", req_of(v), i), r, 32'(f) << v.pin);
      check($sformatf("R11 vec %0d irq_lo", i), {31'h0, irq_lo}, 32'(f && v.pin < 16));
      check($sformatf("R11 vec %0d irq_hi", i), {31'h0, irq_hi}, 32'(f && v.pin >= 16));
    end

    // R6 level re-sets after clear; R11 masking
    pad_in = '1;
    wr(8'h0C, 0); wr(8'h10, 0); wr(8'h1C, 0); wr(8'h14, 0);
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    pad_in[3] = 1'b0;
    idle(5);
    check("R11 masked irq_lo", {31'h0, irq_lo}, 0);
    wr(8'h14, 32'h0000_0008);
    check("R11 enabled irq_lo", {31'h0, irq_lo}, 1);
    check("R11 enabled irq_hi", {31'h0, irq_hi}, 0);
    wr(8'h18, 32'h0000_0008);
    rd(8'h18, r); check("R6 level re-sets", r, 32'h0000_0008);
    pad_in[3] = 1'b1;
    idle(4);
    wr(8'h18, 32'h0000_0008);
    rd(8'h18, r); check("R6 clear sticks", r, 32'h0);

    // R9 write of zero keeps a bit
    wr(8'h0C, 32'h0000_8000);        // pin 7 rising
    pad_in[7] = 1'b0;
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    pad_in[7] = 1'b1;
    idle(5);
    wr(8'h18, 32'h0);
    rd(8'h18, r); check("R9 zero write keeps", r, 32'h0000_0080);
    wr(8'h18, 32'h0000_0080);
    rd(8'h18, r); check("R9 one write clears", r, 32'h0);

    // R10 event and clear in the same cycle
    pad_in[7] = 1'b0;
    idle(4);
    @(negedge clk); pad_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 8'h18; we = 1'b1; wdata = 32'h0000_0080;
    @(negedge clk); we = 1'b0;
    rd(8'h18, r); check("R10 set wins", r, 32'h0000_0080);

    // R9 clear one cycle after the event removes it
    pad_in[7] = 1'b0;
    idle(4);
    wr(8'h18, 32'hFFFF_FFFF);
    @(negedge clk); pad_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); addr = 8'h18; we = 1'b1; wdata = 32'h0000_0080;
    @(negedge clk); we = 1'b0;
    rd(8'h18, r); check("R9 late clear", r, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule